// File: doc/BRIEF.md
# Virtual Address Translator with Two-Level Table Walk

This block turns a 32-bit virtual address into a 32-bit physical address for 4 KB pages. Every accepted request is first compared against a small, fully associative buffer of recent translations. On a match the stored frame number is joined with the 12-bit page offset and returned one cycle later, with no memory traffic. On a miss the block walks a two-level page table in memory through a single read port. The top 10 address bits index a first-level table whose location comes from a page-table base input. The next 10 bits index the second-level table named by that entry.

A table entry with its valid bit clear ends the walk with a page fault. A successful walk installs its result in the buffer, using round-robin slot selection. A flush input empties the buffer, for example when the address space changes. Requests come one at a time: the block is ready only while idle, and it answers each request with a single response pulse.

Top module: `pgx_top`

## Requirements
- R1: `req_ready` is 1 only while the block is idle (also right after reset). A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. Each taken request produces exactly one single-cycle `rsp_valid` pulse, and no further request is taken until that pulse has ended.
- R2: The virtual page number is `vaddr[31:12]`. If it matches a valid buffer entry, the response comes in the cycle after acceptance with `rsp_hit`=1 and `rsp_paddr` = {stored frame, `vaddr[11:0]`}, and no memory read is issued.
- R3: On a miss, the first read goes to {`ptbase`, `vaddr[31:22]`, 2'b00}. In every table entry, bit 0 is the valid bit and bits 31:12 hold a frame number; bits 11:1 are ignored. The second read goes to {first-entry frame, `vaddr[21:12]`, 2'b00}. A successful result is {second-entry frame, `vaddr[11:0]`} with `rsp_hit`=0. `ptbase` is sampled when the request is taken.
- R4: `mem_req` stays high with `mem_addr` unchanged until `mem_rvalid` is seen, whatever the read latency. Only one read is outstanding at a time.
- R5: A first-level entry with bit 0 clear ends the walk after exactly one read. A second-level entry with bit 0 clear ends it after two reads. A fault response has `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R6: A successful walk installs the translation, so the next request to the same page hits. A faulting walk installs nothing, so a repeat walks the table again.
- R7: The buffer holds `N_ENTRIES` (default 8) translations. Fills go to a slot pointer that starts at slot 0 after reset and advances by one, wrapping, on each fill. A flush does not move the pointer. With the default size, the ninth distinct fill evicts the first.
- R8: A flush invalidates every entry at the clock edge where it is high. A request taken in the same cycle as a flush is looked up as a miss, and its walk result is installed normally.
- R9: A flush that is high during any cycle of a walk's memory-read phase (after acceptance) suppresses that walk's fill. The response itself is still delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffered translations |
| ptbase | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from the buffer |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req | output | 1 | Table read request, held until served |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry read back |

## Verification
Flush and lookup can fall in the same cycle, and so can flush and walk completion. The bench provokes the first by raising `flush` together with a request for a page it knows is buffered. It provokes the second by raising `flush` during the first read of a walk while the memory model answers with latencies of one to four cycles. A reference model of the buffer, with slot pointer and suppressed-fill rule, predicts hit or miss and the number of table reads for every later request. Any disagreement in hit, fault, address or read count is reported.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFS_W = 12;
    localparam int IDX_W = 10;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PFN_W = PA_W - OFS_W;
    localparam int PTE_V = 0;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_RD1,
        WK_RD2,
        WK_RESP
    } wk_state_e;
endpackage

// File: rtl/pgx_store.sv
module pgx_store
    import pgx_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    output logic             lk_hit_o,
    output logic [PFN_W-1:0] lk_pfn_o,
    input  logic             fill_en_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PFN_W-1:0] fill_pfn_i
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    typedef struct packed {
        logic [N-1:0]            vld;
        logic [N-1:0][VPN_W-1:0] vpn;
        logic [N-1:0][PFN_W-1:0] pfn;
        logic [PW-1:0]           ptr;
    } store_t;

    store_t       st_d, st_q;
    logic [N-1:0] match;

    // parallel compare of every slot against the looked-up page
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = st_q.vld[g] && (st_q.vpn[g] == lk_vpn_i);
    end

    always_comb begin
        lk_pfn_o = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) lk_pfn_o = lk_pfn_o | st_q.pfn[i];
        end
    end

    // a flush in the lookup cycle wins over any stored match
    assign lk_hit_o = (|match) && !flush_i;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.vld = '0;
        end else if (fill_en_i) begin
            st_d.vld[st_q.ptr] = 1'b1;
            st_d.vpn[st_q.ptr] = fill_vpn_i;
            st_d.pfn[st_q.ptr] = fill_pfn_i;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pgx_walk.sv
module pgx_walk
    import pgx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [PFN_W-1:0] ptbase_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic             lk_hit_i,
    input  logic [PFN_W-1:0] lk_pfn_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic             rsp_fault_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic             mem_req_o,
    output logic [PA_W-1:0]  mem_addr_o,
    input  logic             mem_rvalid_i,
    input  logic [31:0]      mem_rdata_i,
    output logic             fill_en_o,
    output logic [VPN_W-1:0] fill_vpn_o,
    output logic [PFN_W-1:0] fill_pfn_o
);
    localparam int HI1 = VA_W - 1;
    localparam int HI2 = VA_W - IDX_W - 1;

    typedef struct packed {
        wk_state_e       st;
        logic [VA_W-1:0] va;
        logic [PFN_W-1:0] base;
        logic [PFN_W-1:0] l2;
        logic [PA_W-1:0] pa;
        logic            flt;
        logic            hit;
        logic            stale;
    } walk_t;

    walk_t            wk_d, wk_q;
    logic [PFN_W-1:0] ent_pfn;
    logic             ent_ok;
    logic             unused_pte;

    assign ent_pfn    = mem_rdata_i[31:OFS_W];
    assign ent_ok     = mem_rdata_i[PTE_V];
    assign unused_pte = ^mem_rdata_i[OFS_W-1:1];

    always_comb begin
        wk_d      = wk_q;
        fill_en_o = 1'b0;
        case (wk_q.st)
            WK_IDLE: begin
                if (req_valid_i) begin
                    wk_d.va    = req_vaddr_i;
                    wk_d.base  = ptbase_i;
                    wk_d.stale = 1'b0;
                    wk_d.flt   = 1'b0;
                    wk_d.hit   = 1'b0;
                    wk_d.pa    = '0;
                    if (lk_hit_i) begin
                        wk_d.hit = 1'b1;
                        wk_d.pa  = {lk_pfn_i, req_vaddr_i[OFS_W-1:0]};
                        wk_d.st  = WK_RESP;
                    end else begin
                        wk_d.st  = WK_RD1;
                    end
                end
            end
            WK_RD1: begin
                if (flush_i) wk_d.stale = 1'b1;
                if (mem_rvalid_i) begin
                    if (!ent_ok) begin
                        wk_d.flt = 1'b1;
                        wk_d.st  = WK_RESP;
                    end else begin
                        wk_d.l2  = ent_pfn;
                        wk_d.st  = WK_RD2;
                    end
                end
            end
            WK_RD2: begin
                if (flush_i) wk_d.stale = 1'b1;
                if (mem_rvalid_i) begin
                    wk_d.st = WK_RESP;
                    if (!ent_ok) begin
                        wk_d.flt = 1'b1;
                    end else begin
                        wk_d.pa   = {ent_pfn, wk_q.va[OFS_W-1:0]};
                        fill_en_o = !wk_q.stale && !flush_i;
                    end
                end
            end
            WK_RESP: wk_d.st = WK_IDLE;
            default: wk_d.st = WK_IDLE;
        endcase
    end

    always_comb begin
        case (wk_q.st)
            WK_RD1:  mem_addr_o = {wk_q.base, wk_q.va[HI1 -: IDX_W], 2'b00};
            WK_RD2:  mem_addr_o = {wk_q.l2,   wk_q.va[HI2 -: IDX_W], 2'b00};
            default: mem_addr_o = '0;
        endcase
    end

    assign req_ready_o = (wk_q.st == WK_IDLE);
    assign mem_req_o   = (wk_q.st == WK_RD1) || (wk_q.st == WK_RD2);
    assign rsp_valid_o = (wk_q.st == WK_RESP);
    assign rsp_hit_o   = wk_q.hit;
    assign rsp_fault_o = wk_q.flt;
    assign rsp_paddr_o = wk_q.flt ? '0 : wk_q.pa;
    assign fill_vpn_o  = wk_q.va[VA_W-1:OFS_W];
    assign fill_pfn_o  = ent_pfn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q    <= '0;
            wk_q.st <= WK_IDLE;
        end else begin
            wk_q <= wk_d;
        end
    end
endmodule

// File: rtl/pgx_top.sv
module pgx_top
    import pgx_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [19:0] ptbase,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic        rsp_fault,
    output logic [31:0] rsp_paddr,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata
);
    logic             lk_hit;
    logic [PFN_W-1:0] lk_pfn;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;

    pgx_store #(.N(N_ENTRIES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .lk_vpn_i   (req_vaddr[VA_W-1:OFS_W]),
        .lk_hit_o   (lk_hit),
        .lk_pfn_o   (lk_pfn),
        .fill_en_i  (fill_en),
        .fill_vpn_i (fill_vpn),
        .fill_pfn_i (fill_pfn)
    );

    pgx_walk u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .ptbase_i     (ptbase),
        .req_valid_i  (req_valid),
        .req_ready_o  (req_ready),
        .req_vaddr_i  (req_vaddr),
        .lk_hit_i     (lk_hit),
        .lk_pfn_i     (lk_pfn),
        .rsp_valid_o  (rsp_valid),
        .rsp_hit_o    (rsp_hit),
        .rsp_fault_o  (rsp_fault),
        .rsp_paddr_o  (rsp_paddr),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .fill_en_o    (fill_en),
        .fill_vpn_o   (fill_vpn),
        .fill_pfn_o   (fill_pfn)
    );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_fault,
    input logic [31:0] rsp_paddr,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid
);
    logic [11:0] ofs_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      ofs_q <= '0;
        else if (req_valid && req_ready) ofs_q <= req_vaddr[11:0];
    end

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R1
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $past(req_valid && req_ready)); // R2
    AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !$past(mem_req)); // R2
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == ofs_q)); // R3
    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R4
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!rsp_hit && rsp_paddr == 32'h0)); // R5
    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && req_valid && req_ready) |=> !(rsp_valid && rsp_hit)); // R8
endmodule

bind pgx_top pgx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid)
);

// File: tb/tb_pgx_top.sv
module tb_pgx_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 8;
    localparam logic [19:0] BASE_A = 20'h00100;
    localparam logic [19:0] BASE_B = 20'h00400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [19:0] ptbase = BASE_A;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgx_top #(.N_ENTRIES(NSLOT)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ptbase(ptbase),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // page table memory, word addressed by byte address
    logic [31:0] pmem [logic [31:0]];
    int reads = 0;
    int lat_force = -1;

    function automatic logic [31:0] rd(logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    // reference buffer model
    bit          m_vld [NSLOT];
    logic [19:0] m_vpn [NSLOT];
    logic [19:0] m_pfn [NSLOT];
    int          m_ptr = 0;

    task automatic m_clear();
        for (int i = 0; i < NSLOT; i++) m_vld[i] = 0;
    endtask

    function automatic logic [9:0] l1i(int k);
        return 10'((k * 61 + 3) % 1024);
    endfunction
    function automatic logic [9:0] l2i(int j);
        return 10'((j * 67 + 9) % 1024);
    endfunction
    function automatic logic [31:0] mk_va(int k, int j, logic [11:0] ofs);
        return {l1i(k), l2i(j), ofs};
    endfunction

    task automatic build(logic [19:0] base, logic [3:0] tg);
        for (int k = 0; k < 12; k++) begin
            logic [19:0] l2b = base + 20'(1 + k);
            if (k % 4 != 3) pmem[{base, l1i(k), 2'b00}] = {l2b, 12'h2A5 | 12'h001};
            else            pmem[{base, l1i(k), 2'b00}] = {l2b, 12'h0FE};
            for (int j = 0; j < 16; j++) begin
                logic [19:0] fr = {tg, 8'(k), 8'(j)};
                pmem[{l2b, l2i(j), 2'b00}] = {fr, 11'h2D0, (j % 5 != 4) ? 1'b1 : 1'b0};
            end
        end
    endtask

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    // memory model: one read at a time, latency 1..4 cycles (or forced)
    logic [31:0] lat_addr;
    int          cnt = 0;
    bit          busy = 0;
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (!rst_n) begin
                busy = 0;
            end else if (busy) begin
                if (cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd(lat_addr);
                    busy = 0;
                end else begin
                    cnt--;
                end
            end else if (mem_req) begin
                busy = 1;
                lat_addr = mem_addr;
                cnt = (lat_force >= 0) ? lat_force : int'($urandom_range(0, 3));
                reads++;
            end
        end
    end

    task automatic sflush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        m_clear();
    endtask

    task automatic xlate(logic [31:0] va, bit f_acc, bit f_mid, string r);
        bit          e_hit = 0;
        bit          e_flt = 0;
        logic [31:0] e_pa  = '0;
        int          e_rd  = 0;
        int          waits = 0;
        logic [31:0] e1, e2;
        if (!f_acc)
            for (int i = 0; i < NSLOT; i++)
                if (m_vld[i] && m_vpn[i] == va[31:12]) begin
                    e_hit = 1;
                    e_pa  = {m_pfn[i], va[11:0]};
                end
        if (f_acc) m_clear();
        if (e_hit) f_mid = 0;
        if (!e_hit) begin
            e1 = rd({ptbase, va[31:22], 2'b00});
            e_rd = 1;
            if (!e1[0]) begin
                e_flt = 1;
            end else begin
                e2 = rd({e1[31:12], va[21:12], 2'b00});
                e_rd = 2;
                if (!e2[0]) begin
                    e_flt = 1;
                end else begin
                    e_pa = {e2[31:12], va[11:0]};
                    if (!f_mid) begin
                        m_vld[m_ptr] = 1;
                        m_vpn[m_ptr] = va[31:12];
                        m_pfn[m_ptr] = e2[31:12];
                        m_ptr = (m_ptr + 1) % NSLOT;
                    end
                end
            end
        end
        if (f_mid) m_clear();
        @(negedge clk);
        reads = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        flush = f_acc;
        @(negedge clk);
        req_valid = 1'b0;
        flush = f_mid;
        if (!e_hit && !rsp_valid) chk("R1", "ready during walk", 32'(req_ready), 32'd0);
        while (!rsp_valid && waits < 200) begin
            @(negedge clk);
            flush = 1'b0;
            waits++;
        end
        flush = 1'b0;
        if (waits >= 200) begin
            n_chk++; n_fail++;
            $display("FAIL %s response timeout: actual %0d expected <200", r, waits);
        end
        chk(r, "hit", 32'(rsp_hit), 32'(e_hit));
        chk(r, "fault", 32'(rsp_fault), 32'(e_flt));
        chk(r, "paddr", rsp_paddr, e_pa);
        chk(r, "table reads", 32'(reads), 32'(e_rd));
        if (e_hit) chk("R2", "hit latency", 32'(waits), 32'd0);
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual expired expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_clear();
        build(BASE_A, 4'hA);
        build(BASE_B, 4'hB);
        repeat (3) @(negedge clk);
        chk("R1", "reset ready", 32'(req_ready), 32'd1);
        chk("R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R4", "reset mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", 32'(req_ready), 32'd1);

        // basic walk then buffer hit
        xlate(mk_va(0, 0, 12'h123), 0, 0, "R3");
        xlate(mk_va(0, 0, 12'hABC), 0, 0, "R6");
        @(negedge clk);
        chk("R1", "ready after response", 32'(req_ready), 32'd1);

        // faults at both levels, never installed
        xlate(mk_va(3, 0, 12'h010), 0, 0, "R5");
        xlate(mk_va(12, 1, 12'h020), 0, 0, "R5");
        xlate(mk_va(3, 0, 12'h030), 0, 0, "R6");
        xlate(mk_va(0, 4, 12'h040), 0, 0, "R5");
        xlate(mk_va(0, 4, 12'h050), 0, 0, "R6");
        xlate(mk_va(1, 16, 12'h060), 0, 0, "R5");

        // round-robin eviction
        sflush();
        begin
            int pg[9] = '{0, 1, 2, 3, 5, 6, 7, 8, 10};
            for (int i = 0; i < 9; i++) xlate(mk_va(1, pg[i], 12'h111), 0, 0, "R7");
            for (int i = 1; i < 9; i++) xlate(mk_va(1, pg[i], 12'h222), 0, 0, "R7");
            xlate(mk_va(1, pg[0], 12'h333), 0, 0, "R7");
        end

        // flush coinciding with lookup
        xlate(mk_va(0, 1, 12'h444), 0, 0, "R8");
        xlate(mk_va(0, 1, 12'h445), 1, 0, "R8");
        xlate(mk_va(0, 1, 12'h446), 0, 0, "R8");

        // flush during a walk
        xlate(mk_va(2, 0, 12'h555), 0, 1, "R9");
        xlate(mk_va(2, 0, 12'h556), 0, 0, "R9");
        xlate(mk_va(2, 0, 12'h557), 0, 0, "R9");

        // long fixed latency
        lat_force = 6;
        xlate(mk_va(2, 1, 12'h666), 0, 0, "R4");
        lat_force = -1;

        // context switch
        ptbase = BASE_B;
        sflush();
        xlate(mk_va(0, 0, 12'h777), 0, 0, "R3");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 15) == 0) begin
                ptbase = (ptbase == BASE_A) ? BASE_B : BASE_A;
                sflush();
            end else begin
                int k = int'($urandom_range(0, 13));
                int j = int'($urandom_range(0, 17));
                bit fa = ($urandom_range(0, 11) == 0);
                bit fm = ($urandom_range(0, 7) == 0);
                xlate(mk_va(k, j, 12'($urandom)), fa, fm, "R3");
            end
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule